// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the register front end of one channel of a packet-driven disk DMA engine. Software reaches it through a plain 16-bit memory-mapped bus with byte addresses. Through this bus it sets the channel's control word, reads and clears event status, and programs the command-block count, the address of the next command block, and the thresholds of the inbound and outbound FIFOs. The datapath engine sits next to the block. It receives a one-cycle start strobe, a hold-in-idle level, a register-mode flag, the selected PIO timing mode and the programmed values. It reports completion and error events back to the block, and the block turns them into a level interrupt.

The control word has three active parts. The go bit does not store; a write with go set fires the start strobe once. The engine-reset bit holds the engine idle for as long as it stays set. The mask bit gates the interrupt. The status word collects events until software reads it, and a read returns the current contents and clears them in the same access.

Top module: `dmachan_regs`

## Requirements
- R1: After reset, the control word reads 0x0100 (interrupt masked) and status reads 0. The command-block count reads 1, both next-pointer halves read 0, and both FIFO thresholds read 0x100. eng_reg_mode is 1 and irq and eng_start are 0.
- R2: The control word is at byte offset 0x00. Bit 8 is the interrupt mask (1 = masked), bit 5 is engine reset and bits 1:0 are the PIO mode (value 3 selects mode 4). These bits read back as written. Bit 7 (go) and all other bits read 0.
- R3: A control write with bit 7 set and bit 5 clear drives eng_start high for exactly the one cycle after the write edge.
- R4: While the engine-reset bit is set, eng_hold_idle is 1 and incoming events do not set status bits. A control write that sets go and reset together gives no start strobe.
- R5: A control write with go clear sets eng_reg_mode to 1. A control write with go set clears it. Both take effect at the write edge.
- R6: Events set sticky status bits at offset 0x02: protocol error on bit 6, unexpected interrupt on bit 4, completion done on bit 2 and bus error on bit 0.
- R7: A status read returns the contents held before the read and clears all status bits. An event that arrives in the same cycle as the read is kept.
- R8: irq is 1 exactly when some status bit is set and the mask is clear. It is a registered output that changes at the same edge as the status or the mask.
- R9: These registers read and write in full: the count at 0x04, the next pointer low half at 0x0C and high half at 0x0E, the input threshold at 0x14 and the output threshold at 0x16. Their values drive cb_count, cb_next_ptr, thr_in and thr_out.
- R10: Read data appears on bus_rdata after the edge that accepts the read and holds until the next read. Unmapped offsets read 0, and writes to the status offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the halfword (bit 0 ignored) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ev_proto | input | 1 | Engine protocol/state error event |
| ev_unexp | input | 1 | Unexpected device interrupt event |
| ev_done | input | 1 | Command completion event |
| ev_bus | input | 1 | Bus parity error event |
| eng_start | output | 1 | One-cycle packet start strobe |
| eng_hold_idle | output | 1 | Keeps the engine in idle |
| eng_reg_mode | output | 1 | Channel is in plain register mode |
| eng_pio_mode | output | 2 | Selected PIO timing mode |
| cb_count | output | 16 | Command-block count |
| cb_next_ptr | output | 32 | Next command-block address |
| thr_in | output | 16 | Inbound FIFO threshold |
| thr_out | output | 16 | Outbound FIFO threshold |
| irq | output | 1 | Interrupt request, level |

## Verification
Every result depends on one register stage. A write or an event presented before an edge shows up on eng_start, eng_reg_mode, irq or the programmed outputs just after that edge. Read data is captured at the edge that accepts the read. The bench drives each access or event on a falling edge, lets one rising edge pass, and samples on the next falling edge, where all of these results are settled. The start strobe is checked at that sample and again one cycle later, when it must have dropped. The event sweep walks all sixteen event combinations and computes the expected status word and irq from the bit positions.

// File: rtl/dmachan_pkg.sv
package dmachan_pkg;
  // byte offsets of the halfword registers
  localparam int OFS_CTRL    = 'h00;
  localparam int OFS_STAT    = 'h02;
  localparam int OFS_COUNT   = 'h04;
  localparam int OFS_PTR     = 'h0C;
  localparam int OFS_THR_IN  = 'h14;
  localparam int OFS_THR_OUT = 'h16;

  // control word fields
  localparam int CTL_MASK_BIT = 8;
  localparam int CTL_GO_BIT   = 7;
  localparam int CTL_RST_BIT  = 5;

  // status word fields
  localparam int STS_PROTO_BIT = 6;
  localparam int STS_UNEXP_BIT = 4;
  localparam int STS_DONE_BIT  = 2;
  localparam int STS_BUS_BIT   = 0;

  typedef struct packed {
    logic proto;
    logic unexp;
    logic done;
    logic bus;
  } evt_t;
endpackage

// File: rtl/dmachan_ctrl.sv
module dmachan_ctrl
  import dmachan_pkg::*;
#(
  parameter int DW    = 16,
  parameter int PIO_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    ctrl_view,
  output logic             mask_q,
  output logic             mask_nxt,
  output logic             hold_q,
  output logic             reg_mode_q,
  output logic             start_q,
  output logic [PIO_W-1:0] pio_q
);
  logic go_req;
  logic rst_req;

  always_comb begin
    go_req   = wr_ctrl & wdata[CTL_GO_BIT];
    rst_req  = wdata[CTL_RST_BIT];
    mask_nxt = wr_ctrl ? wdata[CTL_MASK_BIT] : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= 1'b1;
      hold_q     <= 1'b0;
      pio_q      <= '0;
      reg_mode_q <= 1'b1;
      start_q    <= 1'b0;
    end else begin
      // go is a trigger only: fires unless the same write asserts reset
      start_q <= go_req & ~rst_req;
      if (wr_ctrl) begin
        mask_q     <= wdata[CTL_MASK_BIT];
        hold_q     <= rst_req;
        pio_q      <= wdata[PIO_W-1:0];
        reg_mode_q <= ~wdata[CTL_GO_BIT];
      end
    end
  end

  always_comb begin
    ctrl_view               = '0;
    ctrl_view[CTL_MASK_BIT] = mask_q;
    ctrl_view[CTL_RST_BIT]  = hold_q;
    ctrl_view[PIO_W-1:0]    = pio_q;
  end
endmodule

// File: rtl/dmachan_stat.sv
module dmachan_stat
  import dmachan_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_stat,
  input  logic          hold,
  input  logic          mask_nxt,
  input  evt_t          ev,
  output logic [DW-1:0] stat_view,
  output logic          irq_q
);
  evt_t st_q;
  evt_t st_d;
  evt_t ev_gated;

  always_comb begin
    ev_gated = hold ? evt_t'('0) : ev;
    st_d     = evt_t'((rd_stat ? 4'b0 : st_q) | ev_gated);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= (|st_d) & ~mask_nxt;
    end
  end

  always_comb begin
    stat_view                = '0;
    stat_view[STS_PROTO_BIT] = st_q.proto;
    stat_view[STS_UNEXP_BIT] = st_q.unexp;
    stat_view[STS_DONE_BIT]  = st_q.done;
    stat_view[STS_BUS_BIT]   = st_q.bus;
  end
endmodule

// File: rtl/dmachan_cfg.sv
module dmachan_cfg
  import dmachan_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 5,
  parameter int PTR_W   = 32,
  parameter int CNT_RST = 1,
  parameter int THR_RST = 'h100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    cnt_q,
  output logic [DW-1:0]    thr_in_q,
  output logic [DW-1:0]    thr_out_q,
  output logic [PTR_W-1:0] ptr_q
);
  localparam int NH = PTR_W / DW;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= DW'(CNT_RST);
      thr_in_q  <= DW'(THR_RST);
      thr_out_q <= DW'(THR_RST);
    end else if (wr_en) begin
      if (addr == AW'(OFS_COUNT))   cnt_q     <= wdata;
      if (addr == AW'(OFS_THR_IN))  thr_in_q  <= wdata;
      if (addr == AW'(OFS_THR_OUT)) thr_out_q <= wdata;
    end
  end

  for (genvar h = 0; h < NH; h++) begin : g_ptr
    logic [DW-1:0] half_q;
    always_ff @(posedge clk) begin
      if (rst)
        half_q <= '0;
      else if (wr_en && addr == AW'(OFS_PTR + 2*h))
        half_q <= wdata;
    end
    assign ptr_q[h*DW +: DW] = half_q;
  end
endmodule

// File: rtl/dmachan_regs.sv
module dmachan_regs
  import dmachan_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 5,
  parameter int PTR_W   = 32,
  parameter int PIO_W   = 2,
  parameter int CNT_RST = 1,
  parameter int THR_RST = 'h100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             ev_proto,
  input  logic             ev_unexp,
  input  logic             ev_done,
  input  logic             ev_bus,
  output logic             eng_start,
  output logic             eng_hold_idle,
  output logic             eng_reg_mode,
  output logic [PIO_W-1:0] eng_pio_mode,
  output logic [DW-1:0]    cb_count,
  output logic [PTR_W-1:0] cb_next_ptr,
  output logic [DW-1:0]    thr_in,
  output logic [DW-1:0]    thr_out,
  output logic             irq
);
  localparam int NH = PTR_W / DW;

  logic [AW-1:0] a_al;
  logic          wr_en;
  logic          rd_en;
  logic          wr_ctrl;
  logic          rd_stat;
  logic [DW-1:0] ctrl_view;
  logic [DW-1:0] stat_view;
  logic          ctl_mask;
  logic          mask_nxt;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rdata_q;
  evt_t          ev;

  always_comb begin
    a_al    = {bus_addr[AW-1:1], 1'b0};
    wr_en   = bus_sel & bus_we;
    rd_en   = bus_sel & ~bus_we;
    wr_ctrl = wr_en & (a_al == AW'(OFS_CTRL));
    rd_stat = rd_en & (a_al == AW'(OFS_STAT));
    ev      = '{proto: ev_proto, unexp: ev_unexp, done: ev_done, bus: ev_bus};
  end

  dmachan_ctrl #(.DW(DW), .PIO_W(PIO_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_ctrl   (wr_ctrl),
    .wdata     (bus_wdata),
    .ctrl_view (ctrl_view),
    .mask_q    (ctl_mask),
    .mask_nxt  (mask_nxt),
    .hold_q    (eng_hold_idle),
    .reg_mode_q(eng_reg_mode),
    .start_q   (eng_start),
    .pio_q     (eng_pio_mode)
  );

  dmachan_stat #(.DW(DW)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .rd_stat  (rd_stat),
    .hold     (eng_hold_idle),
    .mask_nxt (mask_nxt),
    .ev       (ev),
    .stat_view(stat_view),
    .irq_q    (irq)
  );

  dmachan_cfg #(
    .DW(DW), .AW(AW), .PTR_W(PTR_W), .CNT_RST(CNT_RST), .THR_RST(THR_RST)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (a_al),
    .wdata    (bus_wdata),
    .cnt_q    (cb_count),
    .thr_in_q (thr_in),
    .thr_out_q(thr_out),
    .ptr_q    (cb_next_ptr)
  );

  always_comb begin
    rd_mux = '0;
    if (a_al == AW'(OFS_CTRL))    rd_mux = ctrl_view;
    if (a_al == AW'(OFS_STAT))    rd_mux = stat_view;
    if (a_al == AW'(OFS_COUNT))   rd_mux = cb_count;
    if (a_al == AW'(OFS_THR_IN))  rd_mux = thr_in;
    if (a_al == AW'(OFS_THR_OUT)) rd_mux = thr_out;
    for (int h = 0; h < NH; h++)
      if (a_al == AW'(OFS_PTR + 2*h)) rd_mux = cb_next_ptr[h*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/dmachan_regs_chk.sv
module dmachan_regs_chk #(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          ev_proto,
  input logic          ev_unexp,
  input logic          ev_done,
  input logic          ev_bus,
  input logic          eng_start,
  input logic          eng_hold_idle,
  input logic          eng_reg_mode,
  input logic          mask,
  input logic          irq
);
  logic rd_stat, wr_ctrl, ev_any;
  always_comb begin
    rd_stat = bus_sel & ~bus_we & (bus_addr[AW-1:1] == (AW-1)'(1));
    wr_ctrl = bus_sel &  bus_we & (bus_addr[AW-1:1] == '0);
    ev_any  = ev_proto | ev_unexp | ev_done | ev_bus;
  end

  a_r3_start_single: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

  a_r4_hold_no_start: assert property (@(posedge clk) disable iff (rst)
    eng_hold_idle |-> !eng_start);

  a_r5_go_leaves_reg_mode: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && bus_wdata[7]) |=> !eng_reg_mode);

  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !rd_stat && !wr_ctrl) |=> irq);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !ev_any) |=> !irq);

  a_r8_mask_quiets: assert property (@(posedge clk) disable iff (rst)
    mask |-> !irq);
endmodule

bind dmachan_regs dmachan_regs_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_sel      (bus_sel),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .ev_proto     (ev_proto),
  .ev_unexp     (ev_unexp),
  .ev_done      (ev_done),
  .ev_bus       (ev_bus),
  .eng_start    (eng_start),
  .eng_hold_idle(eng_hold_idle),
  .eng_reg_mode (eng_reg_mode),
  .mask         (ctl_mask),
  .irq          (irq)
);

// File: tb/dmachan_regs_test.sv
module dmachan_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ev_proto = 1'b0, ev_unexp = 1'b0, ev_done = 1'b0, ev_bus = 1'b0;
  logic        eng_start, eng_hold_idle, eng_reg_mode, irq;
  logic [1:0]  eng_pio_mode;
  logic [15:0] cb_count, thr_in, thr_out;
  logic [31:0] cb_next_ptr;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  dmachan_regs uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_proto(ev_proto), .ev_unexp(ev_unexp), .ev_done(ev_done), .ev_bus(ev_bus),
    .eng_start(eng_start), .eng_hold_idle(eng_hold_idle),
    .eng_reg_mode(eng_reg_mode), .eng_pio_mode(eng_pio_mode),
    .cb_count(cb_count), .cb_next_ptr(cb_next_ptr),
    .thr_in(thr_in), .thr_out(thr_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [3:0] e);
    @(negedge clk);
    {ev_proto, ev_unexp, ev_done, ev_bus} = e;
    @(negedge clk);
    {ev_proto, ev_unexp, ev_done, ev_bus} = '0;
  endtask

  function automatic logic [15:0] stat_of(input logic [3:0] e);
    return 16'((e[3] << 6) | (e[2] << 4) | (e[1] << 2) | e[0]);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [15:0] pats [4];
    logic [4:0]  cfg_a [5];
    pats[0] = 16'hA5C3; pats[1] = 16'h5A3C; pats[2] = 16'hFFFF; pats[3] = 16'h0000;
    cfg_a[0] = 5'h04; cfg_a[1] = 5'h0C; cfg_a[2] = 5'h0E; cfg_a[3] = 5'h14; cfg_a[4] = 5'h16;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    chk("R1 irq", irq, 0);
    chk("R1 start", eng_start, 0);
    chk("R1 regmode", eng_reg_mode, 1);
    rd(5'h00, d); chk("R1 ctrl", d, 16'h0100);
    rd(5'h02, d); chk("R1 stat", d, 0);
    rd(5'h04, d); chk("R1 count", d, 1);
    rd(5'h0C, d); chk("R1 ptr lo", d, 0);
    rd(5'h0E, d); chk("R1 ptr hi", d, 0);
    rd(5'h14, d); chk("R1 thr in", d, 16'h100);
    rd(5'h16, d); chk("R1 thr out", d, 16'h100);

    // R9 config register sweep
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 5; r++) begin
        logic [15:0] v;
        v = pats[p] ^ 16'(r * 16'h1111);
        wr(cfg_a[r], v);
        rd(cfg_a[r], d);
        chk("R9 readback", d, v);
        case (r)
          0: chk("R9 cb_count", cb_count, v);
          1: chk("R9 ptr lo", cb_next_ptr[15:0], v);
          2: chk("R9 ptr hi", cb_next_ptr[31:16], v);
          3: chk("R9 thr_in", thr_in, v);
          default: chk("R9 thr_out", thr_out, v);
        endcase
      end
    end

    // R2 / R4: all ones -> only mask, reset, pio read back; no start
    wr(5'h00, 16'hFFFF);
    chk("R4 no start with reset", eng_start, 0);
    chk("R4 hold", eng_hold_idle, 1);
    rd(5'h00, d); chk("R2 ctrl readback", d, 16'h0123);
    chk("R2 pio", eng_pio_mode, 3);

    // R5 plain write enters register mode; R3 go strobe
    wr(5'h00, 16'h0003);
    chk("R4 hold released", eng_hold_idle, 0);
    chk("R5 regmode set", eng_reg_mode, 1);
    wr(5'h00, 16'h0083);
    chk("R3 start high", eng_start, 1);
    chk("R5 regmode cleared", eng_reg_mode, 0);
    @(negedge clk);
    chk("R3 start one cycle", eng_start, 0);
    rd(5'h00, d); chk("R2 go reads 0", d, 16'h0003);
    wr(5'h00, 16'h0003);
    chk("R5 regmode back", eng_reg_mode, 1);

    // R6 / R7 / R8 event sweep, unmasked
    for (int e = 0; e < 16; e++) begin
      pulse(4'(e));
      chk("R8 irq follows status", irq, (e != 0));
      rd(5'h02, d); chk("R6 status bits", d, stat_of(4'(e)));
      chk("R7 irq after read", irq, 0);
      rd(5'h02, d); chk("R7 status cleared", d, 0);
    end

    // R8 masked
    wr(5'h00, 16'h0103);
    pulse(4'b0001);
    chk("R8 masked irq", irq, 0);
    wr(5'h00, 16'h0003);
    chk("R8 unmask raises irq", irq, 1);
    rd(5'h02, d); chk("R6 bus bit kept while masked", d, 16'h0001);

    // R7 event during read is kept
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 5'h02; ev_proto = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; ev_proto = 1'b0;
    chk("R7 read returns old", bus_rdata, 0);
    chk("R7 irq from kept event", irq, 1);
    rd(5'h02, d); chk("R7 event kept", d, 16'h0040);

    // R4 events ignored while held, go suppressed
    wr(5'h00, 16'h0023);
    pulse(4'b0100);
    chk("R4 irq held", irq, 0);
    rd(5'h02, d); chk("R4 event ignored", d, 0);
    wr(5'h00, 16'h00A3);
    chk("R4 go suppressed", eng_start, 0);
    wr(5'h00, 16'h0003);

    // R10 unmapped read, status write ignored, hold of rdata
    rd(5'h08, d); chk("R10 unmapped", d, 0);
    wr(5'h02, 16'hFFFF);
    chk("R10 status write no irq", irq, 0);
    rd(5'h02, d); chk("R10 status write ignored", d, 0);
    rd(5'h14, d);
    @(negedge clk);
    chk("R10 rdata holds", bus_rdata, d);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule